// File: doc/BRIEF.md
# NAND Flash Strobe Sequencer

This block sits between a simple register port and a raw 8-bit NAND flash device. Software writes a command byte, address bytes or data bytes to the block. Each accepted write becomes one qualified write cycle on the flash pins. A read of the data register becomes one read-strobe cycle, and the sampled byte is returned on the register port. Every phase of a bus cycle is stretched by a cycle count held in a packed timing register, so one design fits a range of flash speed grades and bus clock rates.

A mode register and the timing register are guarded by a single-use key. The mode register sets the page size, the address length, the bus width and a software write protect. The controller also tracks how many address bytes follow the last command. One command value aborts any cycle in progress and is passed on to the flash as its reset. Another command value, the spare-area read, is rewritten on the bus as a plain page read and marks the spare area as the target.

Top module: `nand_strobe_ctrl`

## Requirements
- R1: Register offsets are 0 command, 1 address, 2 data, 3 status, 4 mode, 5 timing, 6 key, 7 chip-enable hold. After reset the pins are idle (nand_ce_n=1, nand_cle=0, nand_ale=0, nand_we_n=1, nand_re_n=1, nand_io_oe=0, nand_io_out=0), and mode and timing read back as 0. Reads of offsets 3, 4 and 5 return a value with reg_rvalid one cycle later. Reads of offsets 0, 1, 6 and 7 return 0.
- R2: A write to offset 0 runs a command cycle on the pins. It has a setup phase, a strobe phase with nand_we_n low, and a hold phase. In all three, nand_cle=1, nand_ce_n=0, nand_io_oe=1, and nand_io_out carries the byte. A busy-wait phase follows with all qualifiers low.
- R3: A write to offset 1 runs the same setup, strobe and hold phases with nand_ale=1 in place of nand_cle, and no busy-wait phase.
- R4: A write to offset 2 runs the same three phases with neither qualifier high. If mode bit 3 (write protect) is set, the write is dropped and no cycle runs.
- R5: A read of offset 2 runs a setup phase, a strobe phase with nand_re_n low and nand_io_oe=0, a hold phase and a bus-release phase. nand_io_in is sampled at the edge that ends the strobe phase. It is returned zero-extended with a one-cycle reg_rvalid pulse in the next cycle.
- R6: Timing fields, low bit first: write strobe [3:0], write hold [7:4], read strobe [11:8], read hold [15:12], bus release [18:16], busy-wait [23:19], setup [25:24]. A phase lasts as many clocks as its field holds, and one clock when the field is 0.
- R7: A write to mode or timing takes effect only if the register write just before it was 0xA25E to offset 6. Reads in between do not matter. Any other register write uses up the key.
- R8: While a cycle is in progress, writes to offsets 0 to 2 and reads of offset 2 are dropped. Command 0xFF is the only exception.
- R9: Command 0xFF is accepted at any time. It abandons the cycle in progress, with no read result, and clears the chip-enable hold, the spare flag and the address count. It then runs a command cycle carrying 0xFF.
- R10: Command 0x50 goes out on the bus as 0x00 and sets the spare flag. Command 0x00 or 0xFF clears the spare flag.
- R11: Status bit 0 is nand_rb, bit 1 is idle, bit 2 is the spare flag, and bit 3 is set when the number of address writes since the last command equals (mode bit 2 ? 2 : 1) + (mode bit 1 ? 3 : 2). The count saturates at 7.
- R12: Writing 0 to offset 7 holds nand_ce_n low while idle. A nonzero write releases it.
- R13: nand_we_n and nand_re_n are never both low, nand_cle and nand_ale are never both high, and a strobe is low only while nand_ce_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch qualifier |
| nand_ale | output | 1 | Address latch qualifier |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | IOW | Byte driven onto the flash bus |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | IOW | Byte returned by the flash |
| nand_rb | input | 1 | Flash ready/busy line |

## Verification
The bench builds the block with its default parameters: a 32-bit register port, an 8-bit flash bus and the key 0xA25E. The 5-bit busy-wait field and the 4-bit strobe fields can therefore be driven to their largest values, 31 and 15 clocks, within a short run. Zero fields exercise the one-clock minimum. The 3-bit address count is wide enough to reach every address length the mode bits select, and to step past each one.

// File: rtl/nand_strobe_ctrl.sv
`timescale 1ns/1ps
module nand_strobe_ctrl #(
  parameter int          DW         = 32,
  parameter int          IOW        = 8,
  parameter logic [15:0] UNLOCK_KEY = 16'hA25E
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [2:0]     reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           reg_rvalid,
  output logic           nand_ce_n,
  output logic           nand_cle,
  output logic           nand_ale,
  output logic           nand_we_n,
  output logic           nand_re_n,
  output logic [IOW-1:0] nand_io_out,
  output logic           nand_io_oe,
  input  logic [IOW-1:0] nand_io_in,
  input  logic           nand_rb
);
  localparam logic [2:0] A_CMD = 3'd0, A_ADR = 3'd1, A_DAT = 3'd2, A_STA = 3'd3;
  localparam logic [2:0] A_MOD = 3'd4, A_TIM = 3'd5, A_KEY = 3'd6, A_CEH = 3'd7;
  localparam logic [7:0] C_RST = 8'hFF, C_SPARE = 8'h50;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_PULSE, S_HOLD, S_TAIL} phase_t;
  typedef enum logic [1:0] {OP_CMD, OP_ADR, OP_DAT, OP_RD} op_t;

  phase_t         ph;
  op_t            op;
  logic [4:0]     cnt;
  logic [IOW-1:0] obyte;
  logic [3:0]     cfg;
  logic [25:0]    tim;
  logic           key_ok, ce_force, spare;
  logic [2:0]     acnt;

  function automatic logic [4:0] m1(input logic [4:0] x);
    return (x == 5'd0) ? 5'd0 : x - 5'd1;
  endfunction

  wire       idle    = (ph == S_IDLE);
  wire [7:0] cbyte   = reg_wdata[7:0];
  wire       wr_cmd  = reg_wr && reg_addr == A_CMD;
  wire       rst_cmd = wr_cmd && cbyte == C_RST;
  wire       go_cmd  = wr_cmd && (idle || rst_cmd);
  wire       go_adr  = reg_wr && reg_addr == A_ADR && idle;
  wire       go_dat  = reg_wr && reg_addr == A_DAT && idle && !cfg[3];
  wire       go_rd   = reg_rd && reg_addr == A_DAT && idle;
  wire       last    = !idle && cnt == 5'd0;
  wire       cap     = ph == S_PULSE && op == OP_RD && last && !rst_cmd;
  wire [2:0] need    = (cfg[2] ? 3'd2 : 3'd1) + (cfg[1] ? 3'd3 : 3'd2);
  wire [3:0] status  = {acnt == need, spare, idle, nand_rb};
  wire       in_bus  = ph == S_SETUP || ph == S_PULSE || ph == S_HOLD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= S_IDLE; op <= OP_CMD; cnt <= '0; obyte <= '0;
    end else if (go_cmd || go_adr || go_dat || go_rd) begin
      ph    <= S_SETUP;
      cnt   <= m1({3'b0, tim[25:24]});
      op    <= go_cmd ? OP_CMD : go_adr ? OP_ADR : go_dat ? OP_DAT : OP_RD;
      obyte <= (go_cmd && cbyte == C_SPARE) ? '0 : reg_wdata[IOW-1:0];
    end else if (last) begin
      case (ph)
        S_SETUP: begin
          ph  <= S_PULSE;
          cnt <= (op == OP_RD) ? m1({1'b0, tim[11:8]}) : m1({1'b0, tim[3:0]});
        end
        S_PULSE: begin
          ph  <= S_HOLD;
          cnt <= (op == OP_RD) ? m1({1'b0, tim[15:12]}) : m1({1'b0, tim[7:4]});
        end
        S_HOLD: begin
          if (op == OP_CMD) begin
            ph <= S_TAIL; cnt <= m1(tim[23:19]);
          end else if (op == OP_RD) begin
            ph <= S_TAIL; cnt <= m1({2'b0, tim[18:16]});
          end else begin
            ph <= S_IDLE;
          end
        end
        default: ph <= S_IDLE;
      endcase
    end else if (!idle) begin
      cnt <= cnt - 5'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; tim <= '0; key_ok <= 1'b0; ce_force <= 1'b0; spare <= 1'b0; acnt <= '0;
    end else begin
      if (reg_wr) key_ok <= reg_addr == A_KEY && reg_wdata[15:0] == UNLOCK_KEY;
      if (reg_wr && key_ok && reg_addr == A_MOD) cfg <= reg_wdata[3:0];
      if (reg_wr && key_ok && reg_addr == A_TIM) tim <= reg_wdata[25:0];
      if (rst_cmd) ce_force <= 1'b0;
      else if (reg_wr && reg_addr == A_CEH) ce_force <= (reg_wdata == '0);
      if (go_cmd) begin
        acnt <= '0;
        if (cbyte == C_SPARE) spare <= 1'b1;
        else if (cbyte == 8'h00 || cbyte == C_RST) spare <= 1'b0;
      end else if (go_adr && acnt != 3'd7) begin
        acnt <= acnt + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0; reg_rdata <= '0;
    end else begin
      reg_rvalid <= 1'b0;
      if (cap) begin
        reg_rvalid <= 1'b1;
        reg_rdata  <= {{(DW-IOW){1'b0}}, nand_io_in};
      end else if (reg_rd && reg_addr != A_DAT) begin
        reg_rvalid <= 1'b1;
        case (reg_addr)
          A_STA:   reg_rdata <= {{(DW-4){1'b0}}, status};
          A_MOD:   reg_rdata <= {{(DW-4){1'b0}}, cfg};
          A_TIM:   reg_rdata <= {{(DW-26){1'b0}}, tim};
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  assign nand_ce_n   = !(!idle || ce_force);
  assign nand_cle    = in_bus && op == OP_CMD;
  assign nand_ale    = in_bus && op == OP_ADR;
  assign nand_we_n   = !(ph == S_PULSE && op != OP_RD);
  assign nand_re_n   = !(ph == S_PULSE && op == OP_RD);
  assign nand_io_oe  = in_bus && op != OP_RD;
  assign nand_io_out = nand_io_oe ? obyte : '0;
endmodule

module nand_strobe_chk #(
  parameter int IOW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           we_n,
  input logic           re_n,
  input logic           cle,
  input logic           ale,
  input logic           ce_n,
  input logic           io_oe,
  input logic [IOW-1:0] io_out,
  input logic [3:0]     cfg,
  input logic [25:0]    tim,
  input logic           key_ok
);
  // R13
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));
  // R13
  qual_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  // R13
  ce_cover_chk: assert property (@(posedge clk) disable iff (!rst_n) (!we_n || !re_n) |-> !ce_n);
  // R5
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !io_oe);
  // R2
  we_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(io_out));
  // R7
  mode_key_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(cfg) |-> $past(key_ok));
  // R7
  timing_key_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(tim) |-> $past(key_ok));
endmodule

bind nand_strobe_ctrl nand_strobe_chk #(.IOW(IOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .we_n(nand_we_n), .re_n(nand_re_n), .cle(nand_cle),
  .ale(nand_ale), .ce_n(nand_ce_n), .io_oe(nand_io_oe), .io_out(nand_io_out),
  .cfg(cfg), .tim(tim), .key_ok(key_ok)
);

// File: tb/tb_nand_strobe_ctrl.sv
`timescale 1ns/1ps
module tb_nand_strobe_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        ce_n, cle, ale, we_n, re_n, io_oe;
  logic [7:0]  io_out;
  logic [7:0]  io_in = 8'h00;
  logic        rb = 1'b1;

  always #2 clk = ~clk;

  nand_strobe_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
    .nand_io_out(io_out), .nand_io_oe(io_oe), .nand_io_in(io_in), .nand_rb(rb)
  );

  int          vectors = 0, miscompares = 0;
  string       tag = "R1";
  logic [14:0] q[$];
  logic [3:0]  m_cfg = '0;
  logic [25:0] m_tim = '0;
  bit          m_key = 0, m_force = 0, m_spare = 0, exp_rv = 0;
  int          m_acnt = 0;
  logic [31:0] exp_rd = '0;

  function automatic int ln(int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic logic [14:0] ent(bit f, bit c, bit cl, bit al, bit w, bit r, bit oe, logic [7:0] b);
    return {f, c, cl, al, w, r, oe, b};
  endfunction

  function automatic logic [31:0] mk_tim(int wp, int wh, int rp, int rh, int rz, int bw, int su);
    return (wp & 15) | ((wh & 15) << 4) | ((rp & 15) << 8) | ((rh & 15) << 12)
         | ((rz & 7) << 16) | ((bw & 31) << 19) | ((su & 3) << 24);
  endfunction

  task automatic push_op(int op, logic [7:0] b);
    logic [7:0] ob = (op == 3) ? 8'h00 : b;
    int n;
    n = ln(int'(m_tim[25:24]));
    for (int i = 0; i < n; i++) q.push_back(ent(0, 0, op == 0, op == 1, 1, 1, op != 3, ob));
    n = (op == 3) ? ln(int'(m_tim[11:8])) : ln(int'(m_tim[3:0]));
    for (int i = 0; i < n; i++)
      q.push_back(ent(op == 3 && i == n - 1, 0, op == 0, op == 1, op == 3, op != 3, op != 3, ob));
    n = (op == 3) ? ln(int'(m_tim[15:12])) : ln(int'(m_tim[7:4]));
    for (int i = 0; i < n; i++) q.push_back(ent(0, 0, op == 0, op == 1, 1, 1, op != 3, ob));
    n = (op == 0) ? ln(int'(m_tim[23:19])) : (op == 3) ? ln(int'(m_tim[18:16])) : 0;
    for (int i = 0; i < n; i++) q.push_back(ent(0, 0, 0, 0, 1, 1, 0, 8'h00));
  endtask

  task automatic model_edge(bit wr, bit rd, logic [2:0] a, logic [31:0] d);
    bit busy = q.size() > 0;
    bit rst  = wr && a == 3'd0 && d[7:0] == 8'hFF;
    bit hf   = busy ? q[0][14] : 1'b0;
    int need = (m_cfg[2] ? 2 : 1) + (m_cfg[1] ? 3 : 2);
    exp_rv = 0;
    if (hf && !rst) begin
      exp_rv = 1; exp_rd = {24'h0, io_in};
    end else if (rd && a != 3'd2) begin
      exp_rv = 1;
      case (a)
        3'd3: exp_rd = {28'h0, m_acnt == need, m_spare, !busy, rb};
        3'd4: exp_rd = {28'h0, m_cfg};
        3'd5: exp_rd = {6'h0, m_tim};
        default: exp_rd = '0;
      endcase
    end
    if (busy) void'(q.pop_front());
    if (rst) q.delete();
    if (wr && a == 3'd0 && (rst || !busy)) begin
      push_op(0, (d[7:0] == 8'h50) ? 8'h00 : d[7:0]);
      m_acnt = 0;
      if (d[7:0] == 8'h50) m_spare = 1;
      else if (d[7:0] == 8'h00 || d[7:0] == 8'hFF) m_spare = 0;
    end else if (wr && a == 3'd1 && !busy) begin
      push_op(1, d[7:0]);
      if (m_acnt < 7) m_acnt++;
    end else if (wr && a == 3'd2 && !busy && !m_cfg[3]) begin
      push_op(2, d[7:0]);
    end else if (rd && a == 3'd2 && !busy) begin
      push_op(3, 8'h00);
    end
    if (wr && m_key && a == 3'd4) m_cfg = d[3:0];
    if (wr && m_key && a == 3'd5) m_tim = d[25:0];
    if (rst) m_force = 0;
    else if (wr && a == 3'd7) m_force = (d == 0);
    if (wr) m_key = (a == 3'd6 && d[15:0] == 16'hA25E);
  endtask

  task automatic compare();
    logic [13:0] exp_p = (q.size() > 0) ? q[0][13:0]
                       : {!m_force, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00};
    logic [13:0] act_p = {ce_n, cle, ale, we_n, re_n, io_oe, io_out};
    vectors++;
    if (act_p !== exp_p) begin
      miscompares++;
      $display("FAIL %s pins act=%h exp=%h t=%0t", tag, act_p, exp_p, $time);
    end
    vectors++;
    if (reg_rvalid !== exp_rv || (exp_rv && reg_rdata !== exp_rd)) begin
      miscompares++;
      $display("FAIL %s read act=%b/%h exp=%b/%h t=%0t", tag, reg_rvalid, reg_rdata, exp_rv, exp_rd, $time);
    end
  endtask

  task automatic step(bit wr, bit rd, logic [2:0] a, logic [31:0] d);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    model_edge(wr, rd, a, d);
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0; reg_rd = 0;
    compare();
  endtask

  task automatic wreg(logic [2:0] a, logic [31:0] d); step(1, 0, a, d); endtask
  task automatic rreg(logic [2:0] a); step(0, 1, a, 32'h0); endtask
  task automatic unlock(); step(1, 0, 3'd6, 32'h0000A25E); endtask
  task automatic drain();
    for (int i = 0; i < 200 && q.size() > 0; i++) step(0, 0, 3'd0, 32'h0);
    step(0, 0, 3'd0, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1"; compare(); rreg(3); rreg(4); rreg(5); rreg(0); rreg(7);

    tag = "R2"; wreg(0, 32'h90); drain();

    tag = "R7";
    wreg(5, mk_tim(3, 2, 4, 1, 2, 5, 2)); rreg(5);
    unlock(); wreg(5, mk_tim(3, 2, 4, 1, 2, 5, 2)); rreg(5);
    unlock(); wreg(3, 32'h0); wreg(5, 32'h0); rreg(5);
    step(1, 0, 3'd6, 32'h0000A25F); wreg(4, 32'hF); rreg(4);
    unlock(); rreg(4); wreg(4, 32'h6); rreg(4);

    tag = "R2"; wreg(0, 32'h80); drain();
    tag = "R3"; wreg(1, 32'h12); drain(); wreg(1, 32'h34); drain();

    tag = "R11";
    wreg(0, 32'h00); drain();
    for (int i = 0; i < 4; i++) begin wreg(1, 32'h20 + i); drain(); end
    rreg(3); wreg(1, 32'h24); drain(); rreg(3); wreg(1, 32'h25); drain(); rreg(3);
    unlock(); wreg(4, 32'h0); wreg(0, 32'h00); drain();
    for (int i = 0; i < 3; i++) begin wreg(1, 32'h40 + i); drain(); end
    rreg(3); rb = 1'b0; rreg(3); rb = 1'b1; rreg(3);

    tag = "R4"; wreg(2, 32'h5A); drain();
    unlock(); wreg(4, 32'h8); wreg(2, 32'h33); step(0, 0, 0, 0); step(0, 0, 0, 0);
    unlock(); wreg(4, 32'h6); wreg(2, 32'hC3); drain();

    tag = "R5"; io_in = 8'hA7; rreg(2); drain(); io_in = 8'h3C; rreg(2); rreg(3); drain();

    tag = "R8"; wreg(1, 32'h01); wreg(0, 32'h30); wreg(2, 32'h77); rreg(2); drain(); rreg(3);

    tag = "R10"; wreg(0, 32'h50); drain(); rreg(3); wreg(0, 32'h00); drain(); rreg(3);

    tag = "R12"; wreg(7, 32'h0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    wreg(7, 32'h100); step(0, 0, 0, 0);

    tag = "R9"; wreg(0, 32'h50); drain(); wreg(1, 32'h9); drain(); wreg(7, 32'h0);
    io_in = 8'h5E; rreg(2); step(0, 0, 0, 0); step(0, 0, 0, 0); wreg(0, 32'hFF); drain(); rreg(3);

    tag = "R6";
    unlock(); wreg(5, mk_tim(15, 0, 0, 0, 0, 31, 3)); wreg(0, 32'h70); drain(); wreg(1, 32'h5); drain();
    unlock(); wreg(5, mk_tim(0, 15, 15, 15, 7, 0, 0)); wreg(2, 32'hE1); drain();
    io_in = 8'h81; rreg(2); drain(); rreg(5);

    tag = "R13";
    unlock(); wreg(5, 32'h0);
    for (int i = 0; i < 6; i++) begin wreg(i[0] ? 3'd1 : 3'd0, 32'h10 + i); drain(); end
    io_in = 8'hF0; rreg(2); drain();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule